// File: doc/BRIEF.md
# Video DRAM Array with Block-Write Fill

This block is a cycle-based model of a small video DRAM array of 4-bit words. The address bus is multiplexed: the row is taken when the row strobe falls and the column when the column strobe falls. Besides normal reads and writes, it supports a block-write cycle. That cycle copies a stored 4-bit color value into any subset of an aligned group of four columns in one column cycle. During a block write the data inputs act as per-column enables.

All strobes are active low and are sampled on the rising edge of `clk`. A strobe "falls" when it is seen high on one edge and low on the next. A row period runs from the edge that sees the row strobe fall until the first edge that sees it high again. The function-select line and the write strobe have two uses. At the row fall they decide whether the period loads one of two internal registers (the color value or the plane write mask) or accesses the array. Within an array period they are sampled again at each column fall and pick read, write or block fill. Row and column counts are parameters, so the array can stay small.

Top module: `vram_blkwr`

## Requirements
- R1: After reset, `dq_oe` is low, every array word is 0, the color register is 0 and the plane mask is 4'b1111 (all planes writable).
- R2: At a row fall the row is taken from `addr[ROW_W-1:0]`, and the upper address bits are ignored. At each column fall the column is taken from `addr[COL_W-1:0]`.
- R3: In an array period, a column fall with `dsf`=0 and `we_n`=0 writes `dq_in` into the addressed word. Only the planes whose mask bit is 1 change. `dq_oe` stays low.
- R4: In an array period, a column fall with `dsf`=0 and `we_n`=1 puts the addressed word on `dq_out` and raises `dq_oe` on the following cycle. `dq_oe` falls at the first edge that sees `cas_n` high.
- R5: In an array period, a column fall with `dsf`=1 is a block write. Column bits above bit 1 choose the group of four columns whose low two bits are 00 to 11. `addr[1:0]` are ignored.
- R6: In a block write, `dq_in[j]`=1 writes the group column whose low two column bits equal j. `dq_in[j]`=0 leaves that column unchanged.
- R7: A block write puts bit i of the color register into plane i of every enabled column, only where mask bit i is 1.
- R8: If `dsf`=1 and `we_n`=0 at the row fall, the period is a color load. Each column fall in it stores `dq_in` in the color register, and the array is not changed.
- R9: If `dsf`=1 and `we_n`=1 at the row fall, the period is a mask load. Each column fall in it stores `dq_in` as the plane mask, and the array is not changed.
- R10: A column fall outside a row period changes no word, no register and does not drive `dq_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| dsf | input | 1 | Function select (register load / block write) |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 4 | Write data, register data or block column enables |
| dq_out | output | 4 | Read data |
| dq_oe | output | 1 | High while read data is driven |

## Verification
The block fill and the plane mask act in the same cycle: one column fall decides the enabled columns, the color bits and the masked planes together. The bench provokes this by reloading the mask and color at random between row periods. It then issues block writes with random enable patterns and random ignored low address bits. Each result is judged by reading every affected word back and comparing it with a bench model that merges old word, color and mask per plane.

// File: rtl/vram_blkwr.sv
module vram_blkwr #(
  parameter int ADDR_W = 9,
  parameter int ROWS   = 16,
  parameter int COLS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              dsf,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        dq_in,
  output logic [3:0]        dq_out,
  output logic              dq_oe
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int WA_W  = ROW_W + COL_W;
  localparam int WORDS = 1 << WA_W;

  logic             ras_q, cas_q, ras_act, ld_color, ld_mask;
  logic [ROW_W-1:0] row_q;
  logic [3:0]       color_q, mask_q;
  logic [3:0]       mem [WORDS];

  function automatic logic [3:0] merge(input logic [3:0] old, input logic [3:0] nw,
                                       input logic [3:0] msk);
    return (old & ~msk) | (nw & msk);
  endfunction

  wire             ras_fall = ras_q & ~ras_n;
  wire             cas_fall = cas_q & ~cas_n & ras_act;
  wire [COL_W-1:0] col      = addr[COL_W-1:0];
  wire [WA_W-1:0]  wa       = {row_q, col};
  wire             reg_cyc  = ld_color | ld_mask;
  wire             do_wr    = cas_fall & ~reg_cyc & ~dsf & ~we_n;
  wire             do_blk   = cas_fall & ~reg_cyc & dsf;
  wire             do_rd    = cas_fall & ~reg_cyc & ~dsf & we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      ras_act  <= 1'b0;
      ld_color <= 1'b0;
      ld_mask  <= 1'b0;
      row_q    <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) begin
        ras_act  <= 1'b1;
        row_q    <= addr[ROW_W-1:0];
        ld_color <= dsf & ~we_n;
        ld_mask  <= dsf & we_n;
      end else if (ras_n) begin
        ras_act  <= 1'b0;
        ld_color <= 1'b0;
        ld_mask  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color_q <= 4'h0;
      mask_q  <= 4'hF;
    end else if (cas_fall) begin
      if (ld_color) color_q <= dq_in;
      if (ld_mask)  mask_q  <= dq_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < WORDS; k++) mem[k] <= 4'h0;
    end else begin
      if (do_wr) mem[wa] <= merge(mem[wa], dq_in, mask_q);
      for (int j = 0; j < 4; j++) begin
        if (do_blk && dq_in[j])
          mem[{row_q, col[COL_W-1:2], 2'(j)}] <=
            merge(mem[{row_q, col[COL_W-1:2], 2'(j)}], color_q, mask_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out <= 4'h0;
      dq_oe  <= 1'b0;
    end else if (do_rd) begin
      dq_out <= mem[wa];
      dq_oe  <= 1'b1;
    end else if (cas_n) begin
      dq_oe  <= 1'b0;
    end
  end

  p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |=> dq_oe && dq_out == $past(mem[wa]));

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr || do_blk) |=> !dq_oe);

  p_idle_cas_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_q && !cas_n && !ras_act) |=> $stable(color_q) && $stable(mask_q) && !$rose(dq_oe));

  p_regs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_act |=> $stable(color_q) && $stable(mask_q));

  p_oe_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !dq_oe);
endmodule

// File: tb/vram_blkwr_tb.sv
`timescale 1ns/1ps
module vram_blkwr_tb;
  localparam int ADDR_W = 9, ROWS = 16, COLS = 16;
  logic clk = 0, rst_n = 0, ras_n = 1, cas_n = 1, dsf = 0, we_n = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0] dq_in = '0, dq_out;
  logic dq_oe;
  int n_chk = 0, n_fail = 0, cur_row = 0;
  logic [3:0] m_mem [ROWS*COLS];
  logic [3:0] m_color = 4'h0, m_mask = 4'hF;

  always #2.5 clk = ~clk;

  vram_blkwr #(.ADDR_W(ADDR_W), .ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .dsf(dsf), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic logic [3:0] merge(input logic [3:0] o, input logic [3:0] n, input logic [3:0] m);
    return (o & ~m) | (n & m);
  endfunction

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ras_open(input int row, input bit d, input bit w);
    @(negedge clk);
    addr = ADDR_W'($urandom) & ~ADDR_W'(ROWS-1) | ADDR_W'(row);
    dsf = d; we_n = w; ras_n = 0; cur_row = row;
    @(negedge clk);
    dsf = 0; we_n = 1;
  endtask

  task automatic ras_close();
    @(negedge clk); ras_n = 1;
    @(negedge clk);
  endtask

  task automatic cas(input int col, input bit d, input bit w, input logic [3:0] dq,
                     output logic [3:0] rd, output bit oe);
    @(negedge clk);
    addr = ADDR_W'(col); dsf = d; we_n = w; dq_in = dq; cas_n = 0;
    @(negedge clk);
    rd = dq_out; oe = dq_oe;
    cas_n = 1; dsf = 0; we_n = 1;
    @(negedge clk);
  endtask

  task automatic op_write(input int col, input logic [3:0] d);
    logic [3:0] r; bit oe;
    cas(col, 0, 0, d, r, oe);
    m_mem[cur_row*COLS+col] = merge(m_mem[cur_row*COLS+col], d, m_mask);
    check(!oe, "R3 oe during write", {3'b0, oe}, 4'h0);
  endtask

  task automatic op_read(input int col, input string req);
    logic [3:0] r; bit oe;
    cas(col, 0, 1, $urandom, r, oe);
    check(oe && r == m_mem[cur_row*COLS+col], req, r, m_mem[cur_row*COLS+col]);
    check(dq_oe == 0, "R4 oe release", {3'b0, dq_oe}, 4'h0);
  endtask

  task automatic op_block(input int col, input logic [3:0] en);
    logic [3:0] r; bit oe;
    cas(col, 1, $urandom, en, r, oe);
    for (int j = 0; j < 4; j++) begin
      int a = cur_row*COLS + (col & ~3) + j;
      if (en[j]) m_mem[a] = merge(m_mem[a], m_color, m_mask);
    end
  endtask

  task automatic load_color(input logic [3:0] c);
    logic [3:0] r; bit oe;
    ras_open($urandom_range(ROWS-1), 1, 0);
    cas($urandom_range(COLS-1), $urandom, $urandom, c, r, oe);
    ras_close();
    m_color = c;
  endtask

  task automatic load_mask(input logic [3:0] m);
    logic [3:0] r; bit oe;
    ras_open($urandom_range(ROWS-1), 1, 1);
    cas($urandom_range(COLS-1), $urandom, $urandom, m, r, oe);
    ras_close();
    m_mask = m;
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 4'h1, 4'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] r; bit oe;
    void'($urandom(32'h5eed_0042));
    for (int k = 0; k < ROWS*COLS; k++) m_mem[k] = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(dq_oe == 0, "R1 oe at reset", {3'b0, dq_oe}, 4'h0);
    ras_open(0, 0, 1); op_read(0, "R1 array zero"); op_read(7, "R1 array zero"); ras_close();
    // R1: mask all planes, color zero
    ras_open(2, 0, 1); op_write(5, 4'hF); op_read(5, "R1 mask all enabled");
    op_block(6, 4'hF); op_read(5, "R1 color zero"); ras_close();
    // R5/R6/R7 block write with partial enables, low bits ignored
    load_color(4'hA);
    ras_open(3, 0, 1);
    for (int c = 8; c < 12; c++) op_write(c, 4'h5);
    op_block(9, 4'b0101);
    for (int c = 8; c < 12; c++) op_read(c, "R6 enable pattern");
    ras_close();
    // R7/R3 mask gating
    load_mask(4'b0011);
    ras_open(3, 0, 1);
    op_block(10, 4'b1111);
    op_read(11, "R7 masked fill");
    check(m_mem[3*COLS+11] == 4'b0110, "R7 model", m_mem[3*COLS+11], 4'b0110);
    op_write(4, 4'hF); op_read(4, "R3 masked write");
    ras_close();
    // R8 color load period: multiple CAS, array untouched, last wins
    ras_open(3, 1, 0);
    cas(4, 0, 0, 4'h3, r, oe); cas(8, 1, 0, 4'hC, r, oe);
    ras_close(); m_color = 4'hC;
    load_mask(4'hF);
    ras_open(3, 0, 1); op_read(4, "R8 array untouched"); op_read(8, "R8 array untouched");
    op_block(12, 4'b0001); op_read(12, "R8 color captured"); ras_close();
    // R9 mask load leaves array alone
    ras_open(3, 1, 1); cas(13, 0, 0, 4'h1, r, oe); ras_close(); m_mask = 4'h1;
    ras_open(3, 0, 1); op_read(13, "R9 array untouched"); op_write(13, 4'hF);
    op_read(13, "R9 mask plane 0 only"); ras_close();
    // R10 CAS without RAS
    cas(1, 0, 0, 4'h9, r, oe);
    cas(1, 0, 1, 4'h0, r, oe);
    check(!oe, "R10 no drive", {3'b0, oe}, 4'h0);
    cas(2, 1, 0, 4'hF, r, oe);
    ras_open(0, 0, 1); op_read(1, "R10 ignored write"); op_read(2, "R10 ignored fill"); ras_close();
    load_mask(4'hF);
    ras_open(5, 0, 1); op_block(0, 4'b0001); op_read(0, "R10 color kept"); ras_close();
    // random mix (R2 upper row bits random inside ras_open)
    for (int it = 0; it < 400; it++) begin
      int sel = $urandom_range(9);
      if (sel == 0) load_color($urandom);
      else if (sel == 1) load_mask($urandom);
      else begin
        ras_open($urandom_range(ROWS-1), 0, $urandom);
        for (int k = 0; k < 1 + $urandom_range(3); k++) begin
          int t = $urandom_range(2);
          int c = $urandom_range(COLS-1);
          if (t == 0) op_write(c, $urandom);
          else if (t == 1) op_block(c, $urandom);
          else op_read(c, "R2 R5 R7 random read");
        end
        ras_close();
      end
    end
    for (int rw = 0; rw < ROWS; rw++) begin
      ras_open(rw, 0, 1);
      for (int c = 0; c < COLS; c++) op_read(c, "R6 R7 final sweep");
      ras_close();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule